// File: doc/BRIEF.md
# Maintenance Read Dispatcher

This block receives already-decoded maintenance request descriptors, each carrying a transaction type, a 24-bit configuration offset and an 8-bit transaction ID. Read requests are steered by offset. An offset inside a small local register window is answered by an on-block register stub. Any other offset becomes a read on a memory-mapped master port, which uses a read strobe, an address, a wait-request stall and a read-data-valid return.

External reads are pipelined. A new one can go out on every clock, and up to a configurable number of requests may be waiting for their answers. Returned data is matched to requests strictly in issue order. Every read request produces exactly one response descriptor, which carries the transaction ID, a 32-bit data word and a status code. Responses leave in the order the requests were accepted, whether each read was served locally or externally. Request types other than read are consumed and dropped.

Top module: `maint_read_dispatch`

## Requirements
- R1: A request is a read only when its type field equals 4'b0000. Any other type is accepted and then dropped: it produces no response and no master-port read.
- R2: A read whose offset lies in the local window [0x010000, 0x010100) never reaches the master port. Its response data is 0xC0 in bits 31:24 with the offset in bits 23:0.
- R3: A read whose offset lies outside the window raises `mst_read` with `mst_address` equal to the offset, starting in the cycle after the clock edge that accepts the request.
- R4: While `mst_read` and `mst_waitrequest` are both high, `mst_read` stays high and `mst_address` does not change on the next cycle.
- R5: External reads issue back to back without waiting for data. At least three can be outstanding at the same time.
- R6: Data presented with `mst_readdatavalid` is returned in the response of the oldest external read that has not yet been answered, with that read's transaction ID.
- R7: Responses leave in request acceptance order, including a local read that follows external reads still pending.
- R8: A local read with no earlier response pending shows `rsp_valid` in the cycle right after its accepting edge.
- R9: An external read at the head of the order shows `rsp_valid` in the cycle right after the edge that samples its `mst_readdatavalid`.
- R10: `req_ready` is low when 8 reads are waiting for responses, or when a master read is held by `mst_waitrequest` in the same cycle. Otherwise it is high.
- R11: After reset, `rsp_valid` and `mst_read` are low and `req_ready` is high. Every response has status 2'b00 (OK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_ttype | input | 4 | Transaction type, 4'b0000 = read |
| req_offset | input | 24 | Configuration byte offset |
| req_tid | input | 8 | Transaction ID |
| mst_read | output | 1 | Master read strobe |
| mst_address | output | 24 | Master read address |
| mst_waitrequest | input | 1 | Target stalls the current read |
| mst_readdatavalid | input | 1 | Read data present |
| mst_readdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response descriptor present, one cycle per response |
| rsp_tid | output | 8 | Response transaction ID |
| rsp_data | output | 32 | Response data word |
| rsp_status | output | 2 | Response status, 2'b00 = OK |

## Verification
`req_ready` is combinational in the current cycle and responds to `mst_waitrequest` without a clock. `mst_read` and `mst_address` change one edge after acceptance. A local response is due one edge after acceptance, and an external response one edge after its data-valid sample, provided nothing older is still waiting. The bench drives inputs on the falling edge, then waits 1 ns and compares every output against a queue-based model. The model has moved forward by exactly one rising edge per cycle, so each result is checked in the cycle it is due and in no other.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int TID_W   = 8;
    localparam int TTYPE_W = 4;
    localparam int TAG_W   = DATA_W - ADDR_W;

    localparam logic [TTYPE_W-1:0] TT_MAINT_READ = 4'b0000;
    localparam logic [TAG_W-1:0]   STUB_TAG      = 8'hC0;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_ERROR = 2'b11
    } mrd_status_e;

    typedef enum logic [1:0] {
        RT_DROP   = 2'b00,
        RT_LOCAL  = 2'b01,
        RT_REMOTE = 2'b10
    } mrd_route_e;

    typedef struct packed {
        logic [TTYPE_W-1:0] ttype;
        logic [ADDR_W-1:0]  offset;
        logic [TID_W-1:0]   tid;
    } mrd_req_t;

    typedef struct packed {
        logic              is_local;
        logic [DATA_W-1:0] data;
        logic [TID_W-1:0]  tid;
    } mrd_slot_t;

    typedef struct packed {
        logic [TID_W-1:0]  tid;
        logic [DATA_W-1:0] data;
        mrd_status_e       status;
    } mrd_rsp_t;

    function automatic logic [DATA_W-1:0] stub_word(input logic [ADDR_W-1:0] off);
        return {STUB_TAG, off};
    endfunction
endpackage

// File: rtl/mrd_route.sv
module mrd_route
    import mrd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h010000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 24'h000100
) (
    input  mrd_req_t          req,
    output mrd_route_e        route,
    output logic [DATA_W-1:0] local_data
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + {1'b0, WIN_SIZE};

    logic in_window;

    always_comb begin
        in_window  = ({1'b0, req.offset} >= WIN_LO) && ({1'b0, req.offset} < WIN_HI);
        local_data = stub_word(req.offset);
        if (req.ttype != TT_MAINT_READ) route = RT_DROP;
        else if (in_window)              route = RT_LOCAL;
        else                             route = RT_REMOTE;
    end
endmodule

// File: rtl/mrd_fifo.sv
module mrd_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R10: storage never written past its depth
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    // R6: a pop only ever takes a stored entry
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
endmodule

// File: rtl/mrd_issue.sv
module mrd_issue
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              mst_waitrequest,
    output logic              mst_read,
    output logic [ADDR_W-1:0] mst_address,
    output logic              slot_free
);
    assign slot_free = !mst_read || !mst_waitrequest;

    always_ff @(posedge clk) begin
        if (rst) begin
            mst_read    <= 1'b0;
            mst_address <= '0;
        end else if (load) begin
            mst_read    <= 1'b1;
            mst_address <= load_addr;
        end else if (mst_read && !mst_waitrequest) begin
            mst_read    <= 1'b0;
        end
    end

    // R4: a stalled read keeps strobe and address
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mst_read && mst_waitrequest) |=> (mst_read && $stable(mst_address)));
endmodule

// File: rtl/maint_read_dispatch.sv
module maint_read_dispatch
    import mrd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h010000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 24'h000100,
    parameter int                MAX_PEND = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [TTYPE_W-1:0] req_ttype,
    input  logic [ADDR_W-1:0]  req_offset,
    input  logic [TID_W-1:0]   req_tid,
    output logic               mst_read,
    output logic [ADDR_W-1:0]  mst_address,
    input  logic               mst_waitrequest,
    input  logic               mst_readdatavalid,
    input  logic [DATA_W-1:0]  mst_readdata,
    output logic               rsp_valid,
    output logic [TID_W-1:0]   rsp_tid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [1:0]         rsp_status
);
    localparam int SLOT_W = $bits(mrd_slot_t);
    localparam int CNT_W  = $clog2(MAX_PEND + 1);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + {1'b0, WIN_SIZE};

    mrd_req_t          req;
    mrd_route_e        route;
    logic [DATA_W-1:0] local_data;
    mrd_slot_t         slot_in, slot_head;
    mrd_rsp_t          rsp;

    logic              slot_free, accept, ord_push, ord_pop, ord_full, ord_empty;
    logic              dat_pop, dat_full, dat_empty;
    logic [CNT_W-1:0]  ord_count, dat_count;
    logic [DATA_W-1:0] dat_head;

    assign req = '{ttype: req_ttype, offset: req_offset, tid: req_tid};

    mrd_route #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_route (
        .req        (req),
        .route      (route),
        .local_data (local_data)
    );

    assign req_ready = !ord_full && slot_free;
    assign accept    = req_valid && req_ready;
    assign ord_push  = accept && (route != RT_DROP);
    assign slot_in   = '{is_local: (route == RT_LOCAL), data: local_data, tid: req.tid};

    mrd_issue u_issue (
        .clk             (clk),
        .rst             (rst),
        .load            (accept && (route == RT_REMOTE)),
        .load_addr       (req.offset),
        .mst_waitrequest (mst_waitrequest),
        .mst_read        (mst_read),
        .mst_address     (mst_address),
        .slot_free       (slot_free)
    );

    mrd_fifo #(.WIDTH(SLOT_W), .DEPTH(MAX_PEND)) u_order (
        .clk   (clk),
        .rst   (rst),
        .push  (ord_push),
        .wdata (slot_in),
        .pop   (ord_pop),
        .rdata (slot_head),
        .full  (ord_full),
        .empty (ord_empty),
        .count (ord_count)
    );

    mrd_fifo #(.WIDTH(DATA_W), .DEPTH(MAX_PEND)) u_rdata (
        .clk   (clk),
        .rst   (rst),
        .push  (mst_readdatavalid),
        .wdata (mst_readdata),
        .pop   (dat_pop),
        .rdata (dat_head),
        .full  (dat_full),
        .empty (dat_empty),
        .count (dat_count)
    );

    always_comb begin
        ord_pop    = !ord_empty && (slot_head.is_local || !dat_empty);
        dat_pop    = ord_pop && !slot_head.is_local;
        rsp.tid    = slot_head.tid;
        rsp.data   = slot_head.is_local ? slot_head.data : dat_head;
        rsp.status = ST_OK;
    end

    assign rsp_valid  = ord_pop;
    assign rsp_tid    = rsp.tid;
    assign rsp_data   = rsp.data;
    assign rsp_status = rsp.status;

    // R2: the master port only ever carries offsets outside the local window
    p_remote_outside_r2: assert property (@(posedge clk) disable iff (rst)
        mst_read |-> (({1'b0, mst_address} < WIN_LO) || ({1'b0, mst_address} >= WIN_HI)));
    // R10: nothing is accepted once the pending limit is reached
    p_accept_room_r10: assert property (@(posedge clk) disable iff (rst)
        accept |-> (ord_count < CNT_W'(MAX_PEND)));
    // R6: returned data never outnumbers reads waiting for it
    p_rdata_room_r6: assert property (@(posedge clk) disable iff (rst)
        mst_readdatavalid |-> (!dat_full && (dat_count < ord_count)));
endmodule

// File: tb/maint_read_dispatch_test.sv
module maint_read_dispatch_test;
    import mrd_pkg::*;

    localparam int          DEPTH = 8;
    localparam logic [23:0] WB    = 24'h010000;
    localparam logic [23:0] WE    = 24'h010100;

    typedef struct packed {
        logic        is_local;
        logic [31:0] data;
        logic [7:0]  tid;
    } ent_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [3:0]  req_ttype = '0;
    logic [23:0] req_offset = '0;
    logic [7:0]  req_tid = '0;
    logic        mst_read;
    logic [23:0] mst_address;
    logic        mst_waitrequest = 1'b0, mst_readdatavalid = 1'b0;
    logic [31:0] mst_readdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_tid;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_status;

    always #4 clk = ~clk;

    maint_read_dispatch uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_ttype(req_ttype), .req_offset(req_offset), .req_tid(req_tid),
        .mst_read(mst_read), .mst_address(mst_address),
        .mst_waitrequest(mst_waitrequest), .mst_readdatavalid(mst_readdatavalid),
        .mst_readdata(mst_readdata),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data), .rsp_status(rsp_status)
    );

    int n_checks = 0, n_fail = 0;
    int cyc = 0, wait_mode = 0, ret_mode = 0;
    bit ret_hold = 0, m_cmd = 0, m_held = 0, saw_full = 0;
    logic [23:0] m_addr = '0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  tid_ctr = 8'h01;
    int max_inflight = 0, dut_rsp = 0, dut_reads = 0, model_reads = 0;
    ent_t        ordq[$];
    logic [31:0] dq[$];
    logic [23:0] slv_q[$];
    mrd_req_t    script[$];

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic add(input logic [3:0] tt, input logic [23:0] off);
        script.push_back('{ttype: tt, offset: off, tid: tid_ctr});
        tid_ctr++;
    endtask

    task automatic step();
        bit w, rdv, acc, rel, exp_ready, exp_rv;
        logic [31:0] rd;
        ent_t h;
        mrd_req_t r;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (wait_mode)
            0: w = 1'b0;
            1: w = cyc[0];
            default: w = lfsr[2] & lfsr[7];
        endcase
        rdv = 1'b0;
        rd  = 32'hDEAD_BEEF;
        if (!ret_hold && slv_q.size() > 0) begin
            if (ret_mode < 0) rdv = lfsr[4] | lfsr[9];
            else rdv = (ret_mode <= 1) || (cyc % ret_mode == 0);
            if (rdv) rd = {8'h5A, slv_q.pop_front()};
        end
        mst_waitrequest   = w;
        mst_readdatavalid = rdv;
        mst_readdata      = rd;
        req_valid = script.size() > 0;
        if (req_valid) begin
            req_ttype  = script[0].ttype;
            req_offset = script[0].offset;
            req_tid    = script[0].tid;
        end
        #1;
        exp_ready = (ordq.size() < DEPTH) && (!m_cmd || !w);
        chk("R10", "req_ready", req_ready, exp_ready);
        if (ordq.size() == DEPTH && req_valid && !req_ready) saw_full = 1;
        chk("R3", "mst_read", mst_read, m_cmd);
        if (m_cmd) chk(m_held ? "R4" : "R3", "mst_address", mst_address, m_addr);
        if (mst_read) dut_reads++;
        exp_rv = ordq.size() > 0 && (ordq[0].is_local || dq.size() > 0);
        if (ordq.size() == 0) chk("R7", "rsp_valid idle", rsp_valid, 1'b0);
        else chk(ordq[0].is_local ? "R8" : "R9", "rsp_valid", rsp_valid, exp_rv);
        if (rsp_valid) dut_rsp++;
        if (exp_rv) begin
            h = ordq.pop_front();
            chk("R7", "rsp_tid", rsp_tid, h.tid);
            if (h.is_local) chk("R2", "rsp_data local", rsp_data, h.data);
            else chk("R6", "rsp_data remote", rsp_data, dq.pop_front());
            chk("R11", "rsp_status", rsp_status, 2'b00);
        end
        if (rdv) dq.push_back(rd);
        acc = req_valid && exp_ready;
        rel = m_cmd && !w;
        if (rel) begin
            slv_q.push_back(m_addr);
            m_cmd = 0;
        end
        if (slv_q.size() > max_inflight) max_inflight = slv_q.size();
        if (acc) begin
            r = script.pop_front();
            if (r.ttype == 4'b0000) begin
                model_reads++;
                if (r.offset >= WB && r.offset < WE)
                    ordq.push_back('{is_local: 1'b1, data: {8'hC0, r.offset}, tid: r.tid});
                else begin
                    ordq.push_back('{is_local: 1'b0, data: 32'h0, tid: r.tid});
                    m_cmd  = 1;
                    m_addr = r.offset;
                end
            end
        end
        m_held = m_cmd && w && !acc;
        cyc++;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (script.size() == 0 && ordq.size() == 0 && !m_cmd && slv_q.size() == 0) break;
            step();
        end
        step();
    endtask

    initial begin
        int r0, m0;
        repeat (3) @(negedge clk);
        chk("R11", "reset rsp_valid", rsp_valid, 1'b0);
        chk("R11", "reset mst_read", mst_read, 1'b0);
        chk("R11", "reset req_ready", req_ready, 1'b1);
        rst = 1'b0;

        // R8: lone local read
        add(4'h0, 24'h010040);
        drain();

        // R1: non-read types in and out of the window
        r0 = dut_rsp; m0 = dut_reads;
        add(4'h1, 24'h000010); add(4'h4, 24'h010080); add(4'h5, 24'h000200); add(4'h8, 24'h010000);
        drain();
        chk("R1", "responses for dropped types", dut_rsp - r0, 0);
        chk("R1", "master reads for dropped types", dut_reads - m0, 0);

        // R5: three pipelined reads before any data returns
        ret_hold = 1;
        add(4'h0, 24'h000010); add(4'h0, 24'h000014); add(4'h0, 24'h000018);
        repeat (6) step();
        chk("R5", "reads in flight", max_inflight, 3);
        ret_hold = 0; ret_mode = 2;
        drain();

        // R7, R2: window edges interleaved with remote reads under stalls
        wait_mode = 1; ret_mode = 3;
        add(4'h0, 24'h00FFFC); add(4'h0, 24'h010000); add(4'h0, 24'h000100); add(4'h0, 24'h0100FC);
        add(4'h0, 24'h010100); add(4'h0, 24'h010004); add(4'h0, 24'h000020); add(4'h0, 24'h010008);
        drain();

        // R10: flood with slow returns
        wait_mode = 0; ret_mode = 5;
        for (int i = 0; i < 24; i++) add(4'h0, (i % 5 == 0) ? WB + 24'(i * 4) : 24'(i * 4));
        drain();
        chk("R10", "stall at pending limit observed", saw_full, 1'b1);

        // mixed traffic
        wait_mode = 2; ret_mode = -1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            add(lfsr[3:0] == 4'hF ? 4'h2 : 4'h0,
                lfsr[5] ? WB + {16'h0, lfsr[11:6], 2'b00} : {14'h0, lfsr[15:8], 2'b00});
        end
        drain();
        chk("R1", "one response per read", dut_rsp, model_reads);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule